// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 256-byte configuration space of a single PCI function. A configuration access port, such as the data window of a host bridge, presents it with byte, halfword or word requests. Reads return little-endian data one cycle after the request. Writes are split into byte lanes and filtered by a fixed protection map. The two status bytes clear the bits that are set in the write data. A word write to a base address register replaces the stored value with a value masked to the region size.

The identity fields, the starting status value and the size and type of each base address register are parameters. They are loaded at reset. From the command register and the base address registers, the block keeps registered decode enables and base addresses for the six regions and for the expansion ROM. The memory and I/O decoders downstream use these outputs directly.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset the space reads back the parameters. The 16-bit vendor ID is at offset 0x00 and the device ID at 0x02. The revision is at 0x08, the 16-bit class code at 0x0A, the header type at 0x0E and the status word at 0x06. Every other byte reads zero, except that an implemented region register holds its type bits.
- R2: The size field selects the read width: 0 is a byte, 1 is a halfword, 2 is a word. Reads are little-endian. A word read ignores address bits 1:0. A halfword read at 0xFF returns only byte 0xFF, zero-extended.
- R3: A write to byte 0x06 or byte 0x07 clears each status bit whose write data bit is 1. It leaves all other status bits unchanged and never sets a bit.
- R4: Byte writes have no effect on these offsets: 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x30–0x33 and 0x3D. With a type-1 header parameter, the range 0x38–0x3B is protected in place of 0x10–0x27 and 0x30–0x33.
- R5: Halfword and word writes act as independent byte writes to consecutive offsets, so protection applies to each byte. A word write aligns its address down to a multiple of 4. A byte lane that would fall past offset 0xFF is dropped.
- R6: A word write to region register n (offset 0x10+4n, n = 0..5) whose size is nonzero stores (data AND NOT(size−1)) OR the region's type bits.
- R7: A word write to the ROM register at 0x30 stores data AND (NOT(size−1) OR 1). Bit 0 is kept as the ROM enable.
- R8: A word write to a region register whose size is zero takes the byte path and has no effect.
- R9: The command register is at 0x04. Bit 0 enables I/O regions, meaning those whose type bit 0 is 1. Bit 1 enables memory regions. The ROM also needs bit 0 of its register to be set. Regions of size zero are never enabled. An enabled base is the stored value with the low size bits cleared. A disabled base reads 0.
- R10: Enables and bases are registered. They change on the clock edge after the edge that stores the write.
- R11: rspValid is high for exactly one cycle, the cycle after each read request. It stays low after write requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqAddr | input | 8 | Byte offset in configuration space |
| reqWdata | input | 32 | Write data, byte lane 0 at bits 7:0 |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data, zero-extended |
| barEnable | output | 6 | Decode enable per region |
| barBase | output | 192 | Region base addresses, region n at bits 32n+31:32n |
| romEnable | output | 1 | Expansion ROM decode enable |
| romBase | output | 32 | Expansion ROM base address |

## Verification
Some properties are checked by assertions on every cycle. The vendor bytes never change. The status word never gains a set bit. Every enabled base is aligned to its region size. An enable only follows a command value that had the matching bit set. A response follows each read one cycle later.

Other behaviour depends on stored data and only the directed scenarios can show it. This covers the exact masked values of the region and ROM registers and the per-byte protection of split word writes. It also covers dropping the lane past 0xFF, the single-byte result of a halfword read at 0xFF, and the one-cycle delay between a stored command and its enables.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int CFG_BYTES = 256;
  localparam int NUM_BARS  = 6;
  localparam int LANES     = 4;
  localparam logic [2:0] ROM_IDX = 3'd6;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // strobes from the request decoder to the storage
  typedef struct packed {
    logic [7:0]       baseAddr;
    logic [LANES-1:0] byteWe;
    logic [LANES-1:0] byteClr;
    logic             barWrite;
    logic [2:0]       barIdx;
    logic             rdEn;
    logic [1:0]       rdSize;
  } cfgStrobe_t;

  function automatic logic isLocked(input logic [7:0] a, input logic bridge);
    logic common, hdr0, hdr1;
    common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E) || (a == 8'h3D);
    hdr0   = (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    hdr1   = (a >= 8'h38 && a <= 8'h3B);
    return common || (bridge ? hdr1 : hdr0);
  endfunction
endpackage

// File: rtl/pci_cfg_ctrl.sv
module pci_cfg_ctrl
  import pci_cfg_pkg::*;
#(
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = '0,
  parameter logic [31:0]               ROM_SIZE = 32'h0,
  parameter bit                        IS_BRIDGE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSize,
  input  logic [7:0] reqAddr,
  output cfgStrobe_t strobe
);
  logic [7:0] alignedAddr;
  logic [7:0] barOfs;
  logic [3:0] laneMask;

  assign alignedAddr = {reqAddr[7:2], 2'b00};
  assign barOfs      = alignedAddr - 8'h10;

  always_comb begin
    strobe   = '0;
    laneMask = 4'b0000;
    if (reqValid && !reqWrite && reqSize != 2'd3) begin
      strobe.rdEn     = 1'b1;
      strobe.rdSize   = reqSize;
      strobe.baseAddr = (reqSize == SZ_WORD) ? alignedAddr : reqAddr;
    end else if (reqValid && reqWrite) begin
      unique case (reqSize)
        SZ_BYTE: begin strobe.baseAddr = reqAddr; laneMask = 4'b0001; end
        SZ_HALF: begin strobe.baseAddr = reqAddr; laneMask = 4'b0011; end
        SZ_WORD: begin
          strobe.baseAddr = alignedAddr;
          if (alignedAddr >= 8'h10 && alignedAddr <= 8'h24 && BAR_SIZE[barOfs[4:2]] != 32'h0) begin
            strobe.barWrite = 1'b1;
            strobe.barIdx   = barOfs[4:2];
          end else if (alignedAddr == 8'h30 && ROM_SIZE != 32'h0) begin
            strobe.barWrite = 1'b1;
            strobe.barIdx   = ROM_IDX;
          end else begin
            laneMask = 4'b1111;
          end
        end
        default: laneMask = 4'b0000;
      endcase
      for (int i = 0; i < LANES; i++) begin
        logic [8:0] laneAddr;
        laneAddr = {1'b0, strobe.baseAddr} + 9'(i);
        if (laneMask[i] && !laneAddr[8]) begin
          if (laneAddr[7:0] == 8'h06 || laneAddr[7:0] == 8'h07)
            strobe.byteClr[i] = 1'b1;
          else if (!isLocked(laneAddr[7:0], IS_BRIDGE))
            strobe.byteWe[i] = 1'b1;
        end
      end
    end
  end

  // R6: a region write never also drives the byte path
  p_bar_path_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.barWrite |-> (strobe.byteWe == '0 && strobe.byteClr == '0));
endmodule

// File: rtl/pci_cfg_datapath.sv
module pci_cfg_datapath
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0]               VENDOR_ID   = 16'h0,
  parameter logic [15:0]               DEVICE_ID   = 16'h0,
  parameter logic [7:0]                REVISION    = 8'h0,
  parameter logic [15:0]               CLASS_CODE  = 16'h0,
  parameter logic [7:0]                HEADER_TYPE = 8'h0,
  parameter logic [15:0]               STATUS_INIT = 16'h0,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE    = '0,
  parameter logic [NUM_BARS-1:0][3:0]  BAR_TYPE    = '0,
  parameter logic [31:0]               ROM_SIZE    = 32'h0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobe_t                 strobe,
  input  logic [31:0]                wdata,
  output logic                       rspValid,
  output logic [31:0]                rspData,
  output logic [NUM_BARS-1:0]        barEnable,
  output logic [NUM_BARS-1:0][31:0]  barBase,
  output logic                       romEnable,
  output logic [31:0]                romBase
);
  logic [7:0]  cfg [CFG_BYTES];
  logic [31:0] barWord;
  logic [31:0] rdWord;
  logic [15:0] cmdNow;
  logic [15:0] statusNow;
  logic [31:0] romNow;

  function automatic logic [7:0] resetByte(input int j);
    logic [7:0] v;
    v = 8'h00;
    case (j)
      0:  v = VENDOR_ID[7:0];
      1:  v = VENDOR_ID[15:8];
      2:  v = DEVICE_ID[7:0];
      3:  v = DEVICE_ID[15:8];
      6:  v = STATUS_INIT[7:0];
      7:  v = STATUS_INIT[15:8];
      8:  v = REVISION;
      10: v = CLASS_CODE[7:0];
      11: v = CLASS_CODE[15:8];
      14: v = HEADER_TYPE;
      default: begin
        if (j >= 16 && j < 16 + 4 * NUM_BARS && (j % 4) == 0 &&
            BAR_SIZE[(j - 16) / 4] != 32'h0)
          v = {4'h0, BAR_TYPE[(j - 16) / 4]};
      end
    endcase
    return v;
  endfunction

  // value stored by a region or ROM word write
  always_comb begin
    if (strobe.barIdx == ROM_IDX)
      barWord = wdata & (~(ROM_SIZE - 32'h1) | 32'h1);
    else if (strobe.barIdx < 3'(NUM_BARS))
      barWord = (wdata & ~(BAR_SIZE[strobe.barIdx] - 32'h1)) | {28'h0, BAR_TYPE[strobe.barIdx]};
    else
      barWord = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < CFG_BYTES; j++) cfg[j] <= resetByte(j);
    end else if (strobe.barWrite) begin
      for (int i = 0; i < LANES; i++)
        cfg[strobe.baseAddr + 8'(i)] <= barWord[8*i +: 8];
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (strobe.byteClr[i])
          cfg[strobe.baseAddr + 8'(i)] <= cfg[strobe.baseAddr + 8'(i)] & ~wdata[8*i +: 8];
        else if (strobe.byteWe[i])
          cfg[strobe.baseAddr + 8'(i)] <= wdata[8*i +: 8];
      end
    end
  end

  // read path
  always_comb begin
    logic [7:0] b0, b1, b2, b3;
    b0 = cfg[strobe.baseAddr];
    b1 = cfg[strobe.baseAddr + 8'd1];
    b2 = cfg[strobe.baseAddr + 8'd2];
    b3 = cfg[strobe.baseAddr + 8'd3];
    unique case (strobe.rdSize)
      SZ_HALF: rdWord = (strobe.baseAddr == 8'hFF) ? {24'h0, b0} : {16'h0, b1, b0};
      SZ_WORD: rdWord = {b3, b2, b1, b0};
      default: rdWord = {24'h0, b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= 32'h0;
    end else begin
      rspValid <= strobe.rdEn;
      if (strobe.rdEn) rspData <= rdWord;
    end
  end

  assign cmdNow    = {cfg[5], cfg[4]};
  assign statusNow = {cfg[7], cfg[6]};
  assign romNow    = {cfg[8'h33], cfg[8'h32], cfg[8'h31], cfg[8'h30]};

  // region decode, one register stage per region
  for (genvar n = 0; n < NUM_BARS; n++) begin : g_bar
    localparam int          OFS   = 16 + 4 * n;
    localparam logic [31:0] SZ    = BAR_SIZE[n];
    localparam bit          IS_IO = BAR_TYPE[n][0];
    logic [31:0] stored;
    logic        enNext;
    assign stored = {cfg[OFS + 3], cfg[OFS + 2], cfg[OFS + 1], cfg[OFS]};
    assign enNext = (SZ != 32'h0) && (IS_IO ? cmdNow[0] : cmdNow[1]);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        barEnable[n] <= 1'b0;
        barBase[n]   <= 32'h0;
      end else begin
        barEnable[n] <= enNext;
        barBase[n]   <= enNext ? (stored & ~(SZ - 32'h1)) : 32'h0;
      end
    end
    if (SZ != 32'h0) begin : g_chk
      p_base_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
        (barBase[n] & (SZ - 32'h1)) == 32'h0);
    end else begin : g_chk_zero
      p_unsized_never_on_r9: assert property (@(posedge clk) disable iff (!rstN)
        !barEnable[n] && barBase[n] == 32'h0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romEnable <= 1'b0;
      romBase   <= 32'h0;
    end else begin
      romEnable <= (ROM_SIZE != 32'h0) && cmdNow[1] && romNow[0];
      romBase   <= ((ROM_SIZE != 32'h0) && cmdNow[1] && romNow[0]) ?
                   (romNow & ~(ROM_SIZE - 32'h1) & ~32'h1) : 32'h0;
    end
  end

  p_vendor_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfg[0] == VENDOR_ID[7:0] && cfg[1] == VENDOR_ID[15:8]);
  p_status_no_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusNow & ~$past(statusNow)) == 16'h0);
  p_enable_needs_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|barEnable) |-> ($past(cmdNow[1:0]) != 2'b00));
  p_rom_needs_bit0_r7: assert property (@(posedge clk) disable iff (!rstN)
    romEnable |-> ($past(romNow[0]) && $past(cmdNow[1])));
  p_rsp_follows_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rspValid);
  p_rsp_only_for_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> !rspValid);
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0]               VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0]               DEVICE_ID   = 16'h7E21,
  parameter logic [7:0]                REVISION    = 8'h05,
  parameter logic [15:0]               CLASS_CODE  = 16'h0C03,
  parameter logic [7:0]                HEADER_TYPE = 8'h00,
  parameter logic [15:0]               STATUS_INIT = 16'h0290,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h1000},
  parameter logic [NUM_BARS-1:0][3:0]  BAR_TYPE    = {4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0},
  parameter logic [31:0]               ROM_SIZE    = 32'h800
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [1:0]               reqSize,
  input  logic [7:0]               reqAddr,
  input  logic [31:0]              reqWdata,
  output logic                     rspValid,
  output logic [31:0]              rspData,
  output logic [NUM_BARS-1:0]      barEnable,
  output logic [NUM_BARS*32-1:0]   barBase,
  output logic                     romEnable,
  output logic [31:0]              romBase
);
  localparam bit IS_BRIDGE = (HEADER_TYPE != 8'h00) && (HEADER_TYPE != 8'h80);

  cfgStrobe_t                strobe;
  logic [NUM_BARS-1:0][31:0] barBaseArr;

  pci_cfg_ctrl #(
    .BAR_SIZE(BAR_SIZE), .ROM_SIZE(ROM_SIZE), .IS_BRIDGE(IS_BRIDGE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .strobe(strobe)
  );

  pci_cfg_datapath #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_CODE(CLASS_CODE), .HEADER_TYPE(HEADER_TYPE), .STATUS_INIT(STATUS_INIT),
    .BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE), .ROM_SIZE(ROM_SIZE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .barEnable(barEnable),
    .barBase(barBaseArr), .romEnable(romEnable), .romBase(romBase)
  );

  assign barBase = barBaseArr;
endmodule

// File: tb/pci_cfg_header_tb.sv
module pci_cfg_header_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [1:0]   reqSize = 2'd0;
  logic [7:0]   reqAddr = 8'h0;
  logic [31:0]  reqWdata = 32'h0;
  logic         rspValid;
  logic [31:0]  rspData;
  logic [5:0]   barEnable;
  logic [191:0] barBase;
  logic         romEnable;
  logic [31:0]  romBase;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pci_cfg_header dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .barEnable(barEnable),
    .barBase(barBase), .romEnable(romEnable), .romBase(romBase)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqSize = sz; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic cfgRead(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqSize = sz;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R11 rspValid after read", {31'h0, rspValid}, 32'h1);
    d = rspData;
  endtask

  task automatic testReset();
    logic [31:0] v;
    cfgRead(8'h00, 2'd2, v); check("R1 vendor/device", v, 32'h7E21A5C3);
    cfgRead(8'h08, 2'd2, v); check("R1 rev/class", v, 32'h0C030005);
    cfgRead(8'h0C, 2'd2, v); check("R1 header type", v, 32'h0);
    cfgRead(8'h04, 2'd2, v); check("R1 status init", v, 32'h02900000);
    cfgRead(8'h14, 2'd2, v); check("R1 io region type", v, 32'h1);
    check("R9 reset enables", {25'h0, romEnable, barEnable}, 32'h0);
  endtask

  task automatic testReads();
    logic [31:0] v;
    cfgRead(8'h01, 2'd1, v); check("R2 half unaligned", v, 32'h000021A5);
    cfgRead(8'h02, 2'd0, v); check("R2 byte", v, 32'h00000021);
    cfgRead(8'h03, 2'd2, v); check("R2 word aligns", v, 32'h7E21A5C3);
    cfgWrite(8'hFE, 2'd0, 32'h77);
    cfgWrite(8'hFF, 2'd0, 32'h5A);
    cfgRead(8'hFF, 2'd1, v); check("R2 half at 0xFF", v, 32'h0000005A);
    cfgRead(8'hFE, 2'd1, v); check("R2 half at 0xFE", v, 32'h00005A77);
    @(negedge clk);
    check("R11 rspValid idle", {31'h0, rspValid}, 32'h0);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    cfgWrite(8'h06, 2'd0, 32'h10);
    cfgRead(8'h06, 2'd1, v); check("R3 clear one bit", v, 32'h0280);
    cfgWrite(8'h06, 2'd1, 32'h0000);
    cfgRead(8'h06, 2'd1, v); check("R3 zero clears none", v, 32'h0280);
    cfgWrite(8'h04, 2'd2, 32'h02000000);
    cfgRead(8'h06, 2'd1, v); check("R3 high byte via word", v, 32'h0080);
  endtask

  task automatic testProtect();
    logic [31:0] v;
    cfgWrite(8'h00, 2'd0, 32'hFF);
    cfgWrite(8'h08, 2'd2, 32'hFFFFFFFF);
    cfgWrite(8'h11, 2'd0, 32'hAB);
    cfgRead(8'h00, 2'd2, v); check("R4 identity locked", v, 32'h7E21A5C3);
    cfgRead(8'h08, 2'd2, v); check("R4 class locked", v, 32'h0C030005);
    cfgRead(8'h10, 2'd2, v); check("R4 region byte locked", v, 32'h0);
    cfgWrite(8'h3C, 2'd2, 32'h11223344);
    cfgRead(8'h3C, 2'd2, v); check("R4 R5 lane 0x3D locked", v, 32'h11220044);
  endtask

  task automatic testSplit();
    logic [31:0] v;
    cfgWrite(8'h41, 2'd2, 32'hDEADBEEF);
    cfgRead(8'h40, 2'd2, v); check("R5 word aligned write", v, 32'hDEADBEEF);
    cfgWrite(8'hFF, 2'd1, 32'hABCD);
    cfgRead(8'hFF, 2'd0, v); check("R5 lane at 0xFF", v, 32'h000000CD);
    cfgRead(8'h00, 2'd0, v); check("R5 lane past 0xFF dropped", v, 32'h000000C3);
  endtask

  task automatic testBars();
    logic [31:0] v;
    cfgWrite(8'h10, 2'd2, 32'hFFFFFFFF);
    cfgRead(8'h10, 2'd2, v); check("R6 mem sizing", v, 32'hFFFFF000);
    cfgWrite(8'h14, 2'd2, 32'hFFFFFFFF);
    cfgRead(8'h14, 2'd2, v); check("R6 io sizing keeps type", v, 32'hFFFFFFE1);
    cfgWrite(8'h10, 2'd2, 32'h12345678);
    cfgRead(8'h10, 2'd2, v); check("R6 mem address", v, 32'h12345000);
    cfgWrite(8'h14, 2'd2, 32'h0000C0E2);
    cfgRead(8'h14, 2'd2, v); check("R6 io address", v, 32'h0000C0E1);
    cfgWrite(8'h30, 2'd2, 32'hFFFFFFFF);
    cfgRead(8'h30, 2'd2, v); check("R7 rom sizing", v, 32'hFFFFF801);
    cfgWrite(8'h30, 2'd2, 32'h00ABC000);
    cfgRead(8'h30, 2'd2, v); check("R7 rom bit0 clear", v, 32'h00ABC000);
    cfgWrite(8'h18, 2'd2, 32'hFFFFFFFF);
    cfgRead(8'h18, 2'd2, v); check("R8 unsized region", v, 32'h0);
  endtask

  task automatic testDecode();
    cfgWrite(8'h04, 2'd0, 32'h01);
    check("R10 enables not yet", {26'h0, barEnable}, 32'h0);
    @(negedge clk);
    check("R10 R9 io enabled", {26'h0, barEnable}, 32'h02);
    check("R9 io base", barBase[63:32], 32'h0000C0E0);
    check("R9 mem base off", barBase[31:0], 32'h0);
    cfgWrite(8'h04, 2'd0, 32'h02);
    @(negedge clk);
    check("R9 mem enabled", {26'h0, barEnable}, 32'h01);
    check("R9 mem base", barBase[31:0], 32'h12345000);
    check("R9 io base off", barBase[63:32], 32'h0);
    check("R9 rom off without bit0", {31'h0, romEnable}, 32'h0);
    cfgWrite(8'h30, 2'd2, 32'h00ABC001);
    @(negedge clk);
    check("R7 R9 rom enabled", {31'h0, romEnable}, 32'h1);
    check("R9 rom base", romBase, 32'h00ABC000);
    cfgWrite(8'h04, 2'd0, 32'h03);
    @(negedge clk);
    check("R9 both enabled, unsized off", {26'h0, barEnable}, 32'h03);
    cfgWrite(8'h04, 2'd0, 32'h00);
    @(negedge clk);
    check("R9 all off", {25'h0, romEnable, barEnable}, 32'h0);
    check("R9 rom base zero", romBase, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReads();
    testStatus();
    testProtect();
    testSplit();
    testBars();
    testDecode();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule